// File: doc/BRIEF.md
# Multidrop Address-Wake Serial Channel

This block is an asynchronous serial transmitter and receiver pair for shared multidrop lines, where one master addresses many listeners. With multidrop operation selected, every character carries an extra tag bit after its data bits. The tag marks the character as an address (1) or as data (0). The transmitter takes the tag value from a configuration bit at the moment a character is loaded. The receiver keeps watching the line even while software has it disabled, so a sleeping station is woken by an address character and ignores traffic meant for other stations.

Received characters that pass the filter are written to a small receive FIFO. Each entry holds the data bits and a status byte. The received tag sits in status bit 5, the bit that would carry the parity error outside this mode. Framing, break and overrun reporting do not depend on the enable state. Bit timing comes from an external enable that pulses at sixteen times the bit rate. Address comparison belongs to software.

Top module: `addrwake_serial`

## Requirements
- R1: Multidrop operation is on only when `cfg_mode` equals 2'b11. Any other value sends and expects frames with no tag bit, and received status bit 5 then reads 0.
- R2: A transmitted frame is one start bit at 0, then 5 + `cfg_dlen` data bits with the LSB first, then the tag bit (multidrop only), then one stop bit at 1, or two when `cfg_stop2` is 1. Each bit lasts 16 `tick16` pulses, and `txd` idles at 1.
- R3: The tag bit sent equals `cfg_tag` as sampled in the cycle the character is accepted. Later changes to `cfg_tag` do not alter that frame.
- R4: `tx_ready` is 1 exactly when the transmitter is idle. A `tx_load` pulse while `tx_ready` is 0 is ignored, and the frame in progress continues unchanged.
- R5: With `rx_en` at 1, every received character is written to the FIFO, whatever its tag.
- R6: In multidrop mode with `rx_en` at 0, a character with tag 1 is written to the FIFO and raises `rd_valid`. A character with tag 0 is discarded.
- R7: `rd_stat[5]` holds the received tag. `rd_data` bits above the programmed data length read 0.
- R8: A first stop bit sampled at 0 sets `rd_stat[6]` (framing error). A frame that is 0 from start through stop sets `rd_stat[7]` (break). A break is written to the FIFO even when the tag filter would drop it.
- R9: The FIFO holds DEPTH (default 4) entries in arrival order. `rd_valid` is 1 while it is not empty, and `rd_pop` removes the head. A character accepted while the FIFO is full is lost and sets `rd_stat[4]` until the next pop.
- R10: Outside multidrop mode, `rx_en` at 0 stops the receiver. A character in progress is abandoned and nothing is written to the FIFO.
- R11: After reset `txd` is 1, `tx_ready` is 1, `rd_valid` is 0, and `rd_data` and `rd_stat` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| cfg_mode | input | 2 | Channel mode; 2'b11 selects multidrop |
| cfg_tag | input | 1 | Tag value for the next loaded character |
| cfg_dlen | input | 2 | Data length code; bits = 5 + code |
| cfg_stop2 | input | 1 | 1 sends two stop bits |
| rx_en | input | 1 | Receiver enable |
| tx_load | input | 1 | Load `tx_data` when `tx_ready` is 1 |
| tx_data | input | 8 | Character to send |
| tx_ready | output | 1 | Transmitter idle |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rd_pop | input | 1 | Remove the FIFO head |
| rd_valid | output | 1 | FIFO not empty |
| rd_data | output | 8 | Head data |
| rd_stat | output | 8 | Head status: 7 break, 6 framing, 5 tag, 4 overrun |

## Verification
The hardest situation to reach is a receiver that is turned off partway through a character. Outside multidrop mode the receiver must drop that character. It must also not mistake the data bits that follow for a new start bit. The bench drives the first few bits of a frame, clears `rx_en`, sends the rest of the frame and some idle time, and only then enables the receiver again. It then confirms that nothing was written and that the next whole frame is received normally. The disabled-but-listening filter and the overrun flag come from table frames and from a burst of five back-to-back characters into the four-entry FIFO.

// File: rtl/aw_pkg.sv
package aw_pkg;
  localparam int FW = 12;  // longest frame: start + 8 data + tag + 2 stop

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       tag;
    logic [7:0] data;
  } rx_char_t;

  function automatic int unsigned data_bits(input logic [1:0] dl);
    return 5 + int'(dl);
  endfunction

  function automatic logic [3:0] frame_bits(input logic [1:0] dl, input logic md,
                                            input logic stop2);
    return 4'(1 + data_bits(dl) + int'(md) + 1 + int'(stop2));
  endfunction

  // samples taken after the start check: data, optional tag, first stop
  function automatic logic [3:0] sample_count(input logic [1:0] dl, input logic md);
    return 4'(data_bits(dl) + int'(md) + 1);
  endfunction

  function automatic logic [7:0] trim(input logic [7:0] d, input logic [1:0] dl);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = (i < int'(data_bits(dl)));
    return d & m;
  endfunction

  function automatic logic [FW-1:0] build_frame(input logic [7:0] d, input logic [1:0] dl,
                                                input logic md, input logic tag);
    logic [FW-1:0] f;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(data_bits(dl))) f[1+i] = d[i];
    if (md) f[1+data_bits(dl)] = tag;
    return f;
  endfunction
endpackage

// File: rtl/aw_tx.sv
module aw_tx
  import aw_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       md,
  input  logic       tag_sel,
  input  logic [1:0] dlen,
  input  logic       stop2,
  input  logic       load,
  input  logic [7:0] data,
  output logic       ready,
  output logic       txd
);
  localparam int CW = $clog2(OVS);

  logic          busy;
  logic [FW-1:0] shreg;
  logic [3:0]    left;
  logic [CW-1:0] tcnt;

  wire accept  = load && !busy;
  wire bit_end = busy && tick && (tcnt == CW'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
      tcnt  <= '0;
    end else if (accept) begin
      shreg <= build_frame(data, dlen, md, tag_sel);
      left  <= frame_bits(dlen, md, stop2);
      tcnt  <= '0;
      busy  <= 1'b1;
    end else if (busy && tick) begin
      if (bit_end) begin
        tcnt  <= '0;
        shreg <= {1'b1, shreg[FW-1:1]};
        left  <= left - 4'd1;
        if (left == 4'd1) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + CW'(1);
      end
    end
  end

  assign ready = !busy;
  assign txd   = busy ? shreg[0] : 1'b1;

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  assert_load_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && load) |=> !ready);
endmodule

// File: rtl/aw_rx.sv
module aw_rx
  import aw_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       md,
  input  logic       en,
  input  logic [1:0] dlen,
  output logic       push,
  output rx_char_t   pchar
);
  localparam int CW = $clog2(OVS);

  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS, R_WAITHI} st_t;

  st_t           st;
  logic [CW-1:0] tcnt;
  logic [3:0]    idx;
  logic [9:0]    sh;

  wire       listen = md || en;
  wire [3:0] nsamp  = sample_count(dlen, md);
  wire       samp   = (st == R_BITS) && tick && (tcnt == CW'(OVS - 1));
  wire       last   = samp && (idx == nsamp - 4'd1);

  logic brk_w, tag_w, keep;

  always_comb begin
    tag_w = md && sh[4'(data_bits(dlen))];
    brk_w = last && !rxd && (sh == '0);
    keep  = brk_w || (md ? (en || tag_w) : en);
  end

  assign push  = listen && last && keep;
  assign pchar = '{brk: brk_w, ferr: !rxd, tag: tag_w, data: trim(sh[7:0], dlen)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= R_IDLE;
      tcnt <= '0;
      idx  <= '0;
      sh   <= '0;
    end else if (!listen) begin
      st   <= R_IDLE;
      tcnt <= '0;
    end else begin
      case (st)
        R_IDLE: begin
          tcnt <= '0;
          if (tick && !rxd) st <= R_START;
        end
        R_START: if (tick) begin
          if (tcnt == CW'(OVS / 2 - 1)) begin
            tcnt <= '0;
            idx  <= '0;
            sh   <= '0;
            st   <= rxd ? R_IDLE : R_BITS;
          end else begin
            tcnt <= tcnt + CW'(1);
          end
        end
        R_BITS: if (tick) begin
          if (samp) begin
            tcnt    <= '0;
            sh[idx] <= rxd;
            idx     <= idx + 4'd1;
            if (last) st <= rxd ? R_IDLE : R_WAITHI;
          end else begin
            tcnt <= tcnt + CW'(1);
          end
        end
        default: if (rxd) st <= R_IDLE;
      endcase
    end
  end

  assert_filter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && md && !en && !pchar.brk) |-> pchar.tag);
  assert_no_tag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !md) |-> !pchar.tag);
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!md && !en) |-> !push);
endmodule

// File: rtl/aw_fifo.sv
module aw_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] rdata,
  output logic         ovr
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  wire full   = (cnt == (AW+1)'(DEPTH));
  wire empty  = (cnt == '0);
  wire pop_ok = pop && !empty;
  wire wr_ok  = push && (!full || pop_ok);

  always_ff @(posedge clk) if (wr_ok) mem[wp] <= wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovr <= 1'b0;
    end else begin
      if (wr_ok)  wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop_ok) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt <= cnt + (AW+1)'(wr_ok) - (AW+1)'(pop_ok);
      if (push && !wr_ok) ovr <= 1'b1;
      else if (pop_ok)    ovr <= 1'b0;
    end
  end

  assign valid = !empty;
  assign rdata = empty ? '0 : mem[rp];

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> ($stable(cnt) && ovr));
endmodule

// File: rtl/addrwake_serial.sv
module addrwake_serial
  import aw_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_tag,
  input  logic [1:0] cfg_dlen,
  input  logic       cfg_stop2,
  input  logic       rx_en,
  input  logic       tx_load,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  output logic       txd,
  input  logic       rxd,
  input  logic       rd_pop,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic [7:0] rd_stat
);
  localparam int CHW = $bits(rx_char_t);

  logic [1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  wire md = (cfg_mode == 2'b11);

  logic     rx_push;
  rx_char_t rx_char, head;
  logic     ovr;

  aw_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .md(md), .tag_sel(cfg_tag),
    .dlen(cfg_dlen), .stop2(cfg_stop2), .load(tx_load), .data(tx_data),
    .ready(tx_ready), .txd(txd)
  );

  aw_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(sync_q[1]), .md(md),
    .en(rx_en), .dlen(cfg_dlen), .push(rx_push), .pchar(rx_char)
  );

  aw_fifo #(.W(CHW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_char), .pop(rd_pop),
    .valid(rd_valid), .rdata(head), .ovr(ovr)
  );

  assign rd_data = head.data;
  assign rd_stat = {head.brk, head.ferr, head.tag, ovr, 4'b0000};

  assert_empty_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == 8'h00));
endmodule

// File: tb/addrwake_serial_test.sv
module addrwake_serial_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b11;
  logic cfg_tag = 1'b0, cfg_stop2 = 1'b0, rx_en = 1'b0;
  logic [1:0] cfg_dlen = 2'd3;
  logic tx_load = 1'b0, rxd = 1'b1, rd_pop = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_ready, txd, rd_valid;
  logic [7:0] rd_data, rd_stat;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  addrwake_serial uut (
    .clk(clk), .rst_n(rst_n), .tick16(1'b1), .cfg_mode(cfg_mode), .cfg_tag(cfg_tag),
    .cfg_dlen(cfg_dlen), .cfg_stop2(cfg_stop2), .rx_en(rx_en), .tx_load(tx_load),
    .tx_data(tx_data), .tx_ready(tx_ready), .txd(txd), .rxd(rxd), .rd_pop(rd_pop),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_stat(rd_stat)
  );

  // fields: [13] multidrop [12] enable [11] tag [10:9] dlen [8:1] data [0] expect stored
  localparam logic [13:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b1, 2'd3, 8'hA5, 1'b1},  // R6 address wakes
    {1'b1, 1'b0, 1'b0, 2'd3, 8'h3C, 1'b0},  // R6 data dropped
    {1'b1, 1'b1, 1'b0, 2'd3, 8'h3C, 1'b1},  // R5 enabled keeps data
    {1'b1, 1'b1, 1'b1, 2'd0, 8'hFF, 1'b1},  // R7 5-bit trim
    {1'b1, 1'b0, 1'b1, 2'd1, 8'h2A, 1'b1},  // R7 6-bit address
    {1'b0, 1'b1, 1'b0, 2'd3, 8'h81, 1'b1},  // R1 plain frame
    {1'b0, 1'b0, 1'b1, 2'd3, 8'h55, 1'b0},  // R10 plain disabled
    {1'b1, 1'b0, 1'b0, 2'd2, 8'h7F, 1'b0}   // R6 7-bit data dropped
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      rxd = v[i];
      repeat (16) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input int nd, input bit md,
                            input bit tag, input bit stop_lvl);
    logic [15:0] v;
    int n;
    v = 16'hFFFF;
    v[0] = 1'b0;
    for (int i = 0; i < nd; i++) v[1+i] = d[i];
    n = 1 + nd;
    if (md) begin v[n] = tag; n++; end
    v[n] = stop_lvl;
    n++;
    send_bits(v, n);
    rxd = 1'b1;
    repeat (32) @(negedge clk);
  endtask

  task automatic pop_one();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
    finish_up();
  end

  initial begin
    logic [11:0] exp_tx;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(txd == 1'b1, "R11 txd", 16'(txd), 16'h1);
    chk(tx_ready == 1'b1, "R11 tx_ready", 16'(tx_ready), 16'h1);
    chk(rd_valid == 1'b0 && rd_stat == 8'h00, "R11 rd", {7'b0, rd_valid, rd_stat}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk through the receive filter
    for (int k = 0; k < 8; k++) begin
      logic md, en, tg, ex;
      logic [1:0] dl;
      logic [7:0] d, m;
      {md, en, tg, dl, d, ex} = VEC[k];
      cfg_mode = md ? 2'b11 : 2'b10;
      rx_en = en;
      cfg_dlen = dl;
      m = 8'hFF >> (3 - dl);
      send_frame(d, 5 + dl, md, tg, 1'b1);
      if (ex) begin
        chk(rd_valid == 1'b1, "R5/R6 stored", 16'(rd_valid), 16'h1);
        chk(rd_data == (d & m), "R7 data", 16'(rd_data), 16'(d & m));
        chk(rd_stat == ((md && tg) ? 8'h20 : 8'h00), "R7/R1 tag in status",
            16'(rd_stat), (md && tg) ? 16'h20 : 16'h0);
        pop_one();
      end else begin
        chk(rd_valid == 1'b0, "R6/R10 dropped", 16'(rd_valid), 16'h0);
      end
    end

    // R8 framing error with receiver enabled
    cfg_mode = 2'b11; cfg_dlen = 2'd3; rx_en = 1'b1;
    send_frame(8'h5A, 8, 1'b1, 1'b0, 1'b0);
    chk(rd_valid && rd_data == 8'h5A && rd_stat == 8'h40, "R8 framing",
        {rd_data, rd_stat}, 16'h5A40);
    pop_one();

    // R8 break while disabled in multidrop
    rx_en = 1'b0;
    send_bits(16'h0000, 12);
    rxd = 1'b1;
    repeat (32) @(negedge clk);
    chk(rd_valid && rd_data == 8'h00 && rd_stat == 8'hC0, "R8 break",
        {rd_data, rd_stat}, 16'h00C0);
    pop_one();
    chk(rd_valid == 1'b0, "R8 break single", 16'(rd_valid), 16'h0);

    // R9 overrun: five characters into four slots
    rx_en = 1'b1;
    for (int i = 0; i < 5; i++) send_frame(8'(8'h10 + i), 8, 1'b1, 1'b0, 1'b1);
    chk(rd_stat[4] == 1'b1, "R9 overrun flag", 16'(rd_stat), 16'h10);
    for (int i = 0; i < 4; i++) begin
      chk(rd_valid && rd_data == 8'(8'h10 + i), "R9 order", 16'(rd_data), 16'(8'h10 + i));
      pop_one();
      chk(rd_stat[4] == 1'b0, "R9 overrun cleared", 16'(rd_stat), 16'h0);
    end
    chk(rd_valid == 1'b0, "R9 fifth lost", 16'(rd_valid), 16'h0);

    // R10 abort mid character outside multidrop
    cfg_mode = 2'b01; rx_en = 1'b1;
    send_bits(16'b1111_1110_0110_0110, 3);
    rx_en = 1'b0;
    send_bits(16'b1111_1111_1100_1100, 8);
    rxd = 1'b1;
    repeat (48) @(negedge clk);
    rx_en = 1'b1;
    repeat (48) @(negedge clk);
    chk(rd_valid == 1'b0, "R10 aborted", 16'(rd_valid), 16'h0);
    send_frame(8'h96, 8, 1'b0, 1'b0, 1'b1);
    chk(rd_valid && rd_data == 8'h96, "R10 resumes", 16'(rd_data), 16'h96);
    pop_one();

    // R2/R3/R4 transmitter: multidrop, 8 bits, two stops, tag 1
    cfg_mode = 2'b11; cfg_dlen = 2'd3; cfg_stop2 = 1'b1; cfg_tag = 1'b1;
    tx_data = 8'hC6;
    exp_tx = {2'b11, 1'b1, 8'hC6, 1'b0};
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    cfg_tag = 1'b0;
    tx_data = 8'h00;
    repeat (8) @(negedge clk);
    for (int b = 0; b < 12; b++) begin
      chk(txd == exp_tx[b], "R2/R3 tx bit", 16'(b * 16 + txd), 16'(b * 16 + exp_tx[b]));
      if (b == 4) begin
        chk(tx_ready == 1'b0, "R4 busy", 16'(tx_ready), 16'h0);
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        repeat (15) @(negedge clk);
      end else begin
        repeat (16) @(negedge clk);
      end
    end
    chk(tx_ready && txd, "R4 idle after frame", {tx_ready, txd}, 16'h3);

    // R1/R2 plain mode, 5 bits, one stop
    cfg_mode = 2'b10; cfg_dlen = 2'd0; cfg_stop2 = 1'b0; cfg_tag = 1'b1;
    tx_data = 8'h13;
    exp_tx = {5'b11111, 1'b1, 5'h13, 1'b0};
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    repeat (8) @(negedge clk);
    for (int b = 0; b < 7; b++) begin
      chk(txd == exp_tx[b], "R1/R2 plain tx bit", 16'(b * 16 + txd), 16'(b * 16 + exp_tx[b]));
      repeat (16) @(negedge clk);
    end
    chk(tx_ready && txd, "R1 no tag bit sent", {tx_ready, txd}, 16'h3);

    finish_up();
  end
endmodule